// File: doc/BRIEF.md
# Dual-Edge Input Capture Register

This block samples a data input twice per clock period, once on the rising edge and once on the falling edge. It returns the two samples as a pair of single-rate outputs, `q1` for the rising-edge sample and `q2` for the falling-edge sample. A static two-bit alignment select decides how the pair is presented:

- **Opposite-edge:** each output moves on its own clock edge.
- **Same-edge:** both outputs move on the rising edge, and `q2` trails `q1` by one cycle.
- **Pipelined same-edge:** the rising and falling samples of one period appear together on the rising edge, one cycle later.

The three alignments use two, three and four storage elements.

A combinational bypass output mirrors the input directly. A build parameter turns the rising-edge capture element into a level-sensitive latch. The latch is transparent while the clock is high. The select is set while the block is held in reset and is not changed during operation.

Top module: `iddr_capture`

## Requirements
- R1: With `mode` = 0 or 3 (opposite-edge), `q1` takes the `din` value present at each rising edge and changes only at rising edges. `q2` takes the `din` value present at each falling edge and changes only at falling edges.
- R2: With `mode` = 1 (same-edge), both outputs change only at rising edges. After a rising edge, `q1` holds the `din` sampled at that edge. `q2` holds the `din` sampled at the falling edge just before it, which belongs to the previous period.
- R3: With `mode` = 2 (pipelined), both outputs change only at rising edges. After a rising edge, `q1` holds the `din` sampled at the previous rising edge. `q2` holds the `din` sampled at the falling edge that followed that previous rising edge.
- R4: `dout` equals `din` at all times, in every mode, regardless of `rst` and `ce`.
- R5: Reset is synchronous and active high. When `rst` is 1 at a clock edge, every register clocked by that edge is cleared to 0, so after a reset period `q1` and `q2` read 0.
- R6: When `ce` is 0 at a clock edge, every register clocked by that edge keeps its value, so the outputs hold.
- R7: With parameter `UPPER_LATCH` = 1, the rising-sample element is a latch. In opposite-edge mode, `q1` follows `din` while `clk` is high and `ce` is 1, keeps the last value while `clk` is low, and reads 0 while `rst` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for all capture and realignment registers |
| din | input | DATA_W | Data to be sampled |
| mode | input | 2 | Alignment select: 0 or 3 opposite-edge, 1 same-edge, 2 pipelined |
| q1 | output | DATA_W | Rising-edge sample output |
| q2 | output | DATA_W | Falling-edge sample output |
| dout | output | DATA_W | Unregistered copy of `din` |

## Verification
The embedded properties check the following on every cycle:

- the falling-edge path of opposite-edge mode;
- the one-cycle and two-cycle latency from `din` to `q1` in same-edge and pipelined modes;
- clearing after reset;
- the hold of the outputs when `ce` was low.

Only the bench scenarios can show the rest. This includes which falling sample is paired with which rising sample in `q2` across modes, and the way the alternate code 3 behaves. It also includes the latch variant's transparency and hold across the two clock phases, and the bypass path, since none of these reduce to a clean single-clock relation.

// File: rtl/iddr_cap_pkg.sv
package iddr_cap_pkg;

  typedef enum logic [1:0] {
    ALIGN_OPPOSITE = 2'd0,
    ALIGN_SAME     = 2'd1,
    ALIGN_PIPE     = 2'd2,
    ALIGN_OPP_ALT  = 2'd3
  } align_mode_e;

endpackage

// File: rtl/iddr_edge_capture.sv
module iddr_edge_capture #(
  parameter int W           = 4,
  parameter bit UPPER_LATCH = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q
);

  logic [W-1:0] rise_r;
  logic [W-1:0] fall_r;

  // Upper element: edge flop or a latch transparent during the high phase
  generate
    if (UPPER_LATCH) begin : g_upper_latch
      always_latch begin
        if (rst)
          rise_r <= '0;
        else if (clk && ce)
          rise_r <= d;
      end
    end else begin : g_upper_flop
      always_ff @(posedge clk) begin
        if (rst)
          rise_r <= '0;
        else if (ce)
          rise_r <= d;
      end
    end
  endgenerate

  // Lower element: always a falling-edge flop
  always_ff @(negedge clk) begin
    if (rst)
      fall_r <= '0;
    else if (ce)
      fall_r <= d;
  end

  assign rise_q = rise_r;
  assign fall_q = fall_r;

endmodule

// File: rtl/iddr_realign.sv
module iddr_realign #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] rise_d,
  output logic [W-1:0] fall_d
);

  // Both samples are moved into the rising-edge domain
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_d <= '0;
      fall_d <= '0;
    end else if (ce) begin
      rise_d <= rise_i;
      fall_d <= fall_i;
    end
  end

endmodule

// File: rtl/iddr_out_select.sv
module iddr_out_select
  import iddr_cap_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [1:0]   mode,
  input  logic [W-1:0] rise_now,
  input  logic [W-1:0] fall_now,
  input  logic [W-1:0] rise_d,
  input  logic [W-1:0] fall_d,
  output logic [W-1:0] q1,
  output logic [W-1:0] q2
);

  align_mode_e sel;

  always_comb begin
    sel = align_mode_e'(mode);
    case (sel)
      ALIGN_SAME: begin
        q1 = rise_now;
        q2 = fall_d;
      end
      ALIGN_PIPE: begin
        q1 = rise_d;
        q2 = fall_d;
      end
      default: begin
        q1 = rise_now;
        q2 = fall_now;
      end
    endcase
  end

endmodule

// File: rtl/iddr_capture.sv
module iddr_capture
  import iddr_cap_pkg::*;
#(
  parameter int DATA_W      = 4,
  parameter bit UPPER_LATCH = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        mode,
  output logic [DATA_W-1:0] q1,
  output logic [DATA_W-1:0] q2,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] rise_now;
  logic [DATA_W-1:0] fall_now;
  logic [DATA_W-1:0] rise_d;
  logic [DATA_W-1:0] fall_d;

  iddr_edge_capture #(.W(DATA_W), .UPPER_LATCH(UPPER_LATCH)) u_capture (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .d      (din),
    .rise_q (rise_now),
    .fall_q (fall_now)
  );

  iddr_realign #(.W(DATA_W)) u_realign (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .rise_i (rise_now),
    .fall_i (fall_now),
    .rise_d (rise_d),
    .fall_d (fall_d)
  );

  iddr_out_select #(.W(DATA_W)) u_select (
    .mode     (mode),
    .rise_now (rise_now),
    .fall_now (fall_now),
    .rise_d   (rise_d),
    .fall_d   (fall_d),
    .q1       (q1),
    .q2       (q2)
  );

  assign dout = din;

  // Edge counters so that no property looks past the start of the run
  logic [1:0] warm_p = 2'd0;
  logic       warm_n = 1'b0;

  always_ff @(posedge clk) begin
    if (warm_p != 2'd3)
      warm_p <= warm_p + 2'd1;
  end

  always_ff @(negedge clk) begin
    warm_n <= 1'b1;
  end

  generate
    if (!UPPER_LATCH) begin : g_props
      // R1: falling sample reaches q2 at the next falling edge
      assert_fall_path_R1: assert property (@(negedge clk) disable iff (rst)
        (warm_n && !$past(rst) && $past(ce) && (mode == 2'd0 || mode == 2'd3))
          |-> (q2 == $past(din)));

      // R2: same-edge q1 carries the previous rising sample
      assert_same_edge_q1_R2: assert property (@(posedge clk) disable iff (rst)
        (warm_p != 2'd0 && !$past(rst) && $past(ce) && mode == 2'd1)
          |-> (q1 == $past(din)));

      // R3: pipelined q1 has two rising edges of latency
      assert_pipe_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (warm_p[1] && !$past(rst, 1) && !$past(rst, 2) &&
         $past(ce, 1) && $past(ce, 2) && mode == 2'd2)
          |-> (q1 == $past(din, 2)));

      // R5: outputs cleared after a reset edge
      assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (warm_p != 2'd0 && $past(rst))
          |-> (q1 == '0 && (mode == 2'd0 || mode == 2'd3 || q2 == '0)));

      // R6: disabled edge holds the rising-domain outputs
      assert_ce_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (warm_p != 2'd0 && !$past(rst) && !$past(ce))
          |-> ($stable(q1) && (mode == 2'd0 || mode == 2'd3 || $stable(q2))));
    end
  endgenerate

endmodule

// File: tb/iddr_capture_tb_top.sv
module iddr_capture_tb_top;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ce  = 1'b0;
  logic [W-1:0] din = '0;
  logic [1:0]   mode = 2'd0;
  logic [W-1:0] q1, q2, dout;
  logic [W-1:0] q1_l, q2_l, dout_l;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference history
  logic [W-1:0] rise_now = '0, rise_prev = '0, fall_now = '0, fall_at_rise = '0;
  logic [W-1:0] lat = '0;
  logic         prev_rst = 1'b1;
  logic [31:0]  seed = 32'h1234_5678;

  always #4 clk = ~clk;  // 125 MHz

  iddr_capture #(.DATA_W(W), .UPPER_LATCH(1'b0)) dut_i (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .mode(mode),
    .q1(q1), .q2(q2), .dout(dout)
  );

  iddr_capture #(.DATA_W(W), .UPPER_LATCH(1'b1)) dut_latch (
    .clk(clk), .rst(rst), .ce(ce), .din(din), .mode(2'd0),
    .q1(q1_l), .q2(q2_l), .dout(dout_l)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] nextval();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[W-1:0];
  endfunction

  task automatic check_main(input logic ce_v, input logic rst_v);
    logic [W-1:0] e1, e2;
    string t;
    case (mode)
      2'd1:    begin e1 = rise_now;  e2 = fall_at_rise; t = "R2"; end
      2'd2:    begin e1 = rise_prev; e2 = fall_at_rise; t = "R3"; end
      default: begin e1 = rise_now;  e2 = fall_now;     t = "R1"; end
    endcase
    if (rst_v || prev_rst) t = "R5";
    else if (!ce_v)        t = "R6";
    chk({t, " q1"}, q1, e1);
    chk({t, " q2"}, q2, e2);
  endtask

  // One clock period, entered and left at rising edge + 2 ns
  task automatic step(input logic [W-1:0] fv, input logic [W-1:0] rv,
                      input logic ce_v, input logic rst_v);
    din = fv; ce = ce_v; rst = rst_v;
    if (rst_v) lat = '0; else if (ce_v) lat = fv;
    #1;
    chk("R7 high phase", q1_l, lat);
    chk("R4", dout, din);
    #1;  // falling edge
    if (rst_v) fall_now = '0; else if (ce_v) fall_now = fv;
    #1;
    check_main(ce_v, rst_v);
    chk("R7 after fall", q1_l, lat);
    #1;
    din = rv;
    #1;
    chk("R4", dout, din);
    chk("R7 low phase hold", q1_l, lat);
    #1;  // rising edge
    if (rst_v) begin
      rise_now = '0; rise_prev = '0; fall_at_rise = '0;
    end else if (ce_v) begin
      rise_prev = rise_now; fall_at_rise = fall_now; rise_now = rv;
    end
    if (rst_v) lat = '0; else if (ce_v) lat = rv;
    #1;
    check_main(ce_v, rst_v);
    chk("R7 at rise", q1_l, lat);
    prev_rst = rst_v;
    #1;
  endtask

  initial begin
    #6;
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      step(nextval(), nextval(), 1'b1, 1'b1);
      step(nextval(), nextval(), 1'b0, 1'b1);
      for (int i = 0; i < 20; i++) step(nextval(), nextval(), 1'b1, 1'b0);
      for (int i = 0; i < 8; i++)  step(nextval(), nextval(), i[0], 1'b0);
      step(nextval(), nextval(), 1'b1, 1'b1);
      for (int i = 0; i < 8; i++)  step(nextval(), nextval(), (i % 3) != 0, 1'b0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule